// File: doc/BRIEF.md
# Keyed-Feed Watchdog and Reset-Cause Keeper

This block is a hardware watchdog that is already running when reset ends, with a default timeout of 16384 clock cycles. Software keeps it from firing by writing a two-byte key to two separate key registers. The same key is the only way to change the control register. A control write only loads a pending copy, and the next valid key copies that pending value into the active register. Stopping the watchdog and turning off the low-voltage reset therefore both need the key.

The block also keeps sticky cause flags for four events: power-on, low supply, oscillator failure and watchdog timeout. It sends a reset request to the rest of the chip when one of these happens:
- the watchdog times out;
- a power-on pulse arrives;
- software sets the software-reset bit;
- the low-voltage detector is high and its enable bit is set;
- the oscillator-fail detector is high and its enable bit is set.

A detector whose enable bit is clear still sets its flag. The reset output is a pulse of a fixed length. That pulse also returns the watchdog's own control register to its defaults. The cause flags are cleared only by the hard reset input or by a software write.

Top module: `wdk_top`

## Requirements
- R1: When `rst_n` is released, `chip_rst_o` stays high for exactly 24 cycles and then goes low. At that point the control register reads 0x14 and the status register reads 0x00.
- R2: With prescale 0 and the run bit set, `chip_rst_o` rises 16384 cycles after the last counter restart if no valid key arrives. The timeout flag (status bit 3) is then set.
- R3: A valid key restarts the count from zero, so the next timeout falls 16384 cycles after the key's second write. The key is 0xA5 written to address 1, with the next write being 0x5A to address 2.
- R4: The key is aborted without a restart or a commit in either of these cases:
  - the write after 0xA5 is anything other than 0x5A to address 2, including a write to another address;
  - 0x5A is written to address 2 when the previous write was not 0xA5 to address 1.
- R5: A write to address 0 has no effect on the control register until a valid key follows. The commit happens in the cycle of the second key write. Control bits 1:0 always read 0.
- R6: Committing a control value with run bit 2 clear stops the count, and no timeout follows.
- R7: Prescale field bits 7:5 equal to p gives a timeout of 16384·2^p cycles.
- R8: A high `lv_low` always sets status bit 1. It starts a reset only while control bit 4 (low-voltage reset enable, default 1) is set.
- R9: A high `osc_bad` always sets status bit 2. It starts a reset only while control bit 3 (oscillator-fail reset enable, default 0) is set.
- R10: A `por_pulse` sets status bit 0 and starts a reset.
  - Status bits 0 to 3 survive every pulse on `chip_rst_o`.
  - A write to address 3 loads bits 3:0 from the written data.
  - A hardware set in the same cycle as that write takes priority.
- R11: Writing address 3 with bit 7 set starts a 24-cycle reset pulse. The pulse restores the control register to 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low; clears everything including the cause flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 first key byte, 2 second key byte, 3 status |
| wr_data | input | 8 | Write data |
| por_pulse | input | 1 | Power-on detector pulse |
| lv_low | input | 1 | Low-supply detector level |
| osc_bad | input | 1 | Oscillator-fail detector level |
| ctrl_q | output | 8 | Active control register: prescale[7:5], lv_en[4], osc_en[3], run[2] |
| status_q | output | 8 | Cause flags: tof[3], osf[2], lvf[1], pof[0]; bits 7:4 read 0 |
| chip_rst_o | output | 1 | Reset request to the chip, active high |

## Verification
Every register write takes effect at the clock edge that captures it. The bench drives on the falling edge and reads the result at the next falling edge, which comes one cycle after the write. A detector pulse or a reset-causing write makes `chip_rst_o` high in that same sample, and it then stays high for 24 samples. Timeout intervals are counted from the sample just after the last restart, whether that restart was a key write or the fall of the reset pulse. The bench counts falling edges until the output rises, so the counted number must equal 16384·2^p exactly. Checks that a condition has no effect read the control or status register, or watch `chip_rst_o`, immediately after the stimulus.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_KEY1 = 2'd1,
    ADR_KEY2 = 2'd2,
    ADR_STAT = 2'd3
  } wdk_addr_e;

  typedef struct packed {
    logic [2:0] pre;
    logic       lv_en;
    logic       osc_en;
    logic       run;
    logic [1:0] rsvd;
  } wdk_ctrl_t;

  localparam wdk_ctrl_t CTRL_DEFAULT = '{pre: 3'd0, lv_en: 1'b1, osc_en: 1'b0,
                                         run: 1'b1, rsvd: 2'b00};

  // flag indices inside the cause vector
  localparam int FLG_POF = 0;
  localparam int FLG_LVF = 1;
  localparam int FLG_OSF = 2;
  localparam int FLG_TOF = 3;
  localparam int N_FLAGS = 4;

  function automatic logic is_write(input logic en, input logic [1:0] addr,
                                    input logic [7:0] data, input wdk_addr_e want_a,
                                    input logic [7:0] want_d);
    return en && (addr == want_a) && (data == want_d);
  endfunction

  function automatic wdk_ctrl_t ctrl_from_byte(input logic [7:0] d);
    wdk_ctrl_t c;
    c = wdk_ctrl_t'(d);
    c.rsvd = 2'b00;
    return c;
  endfunction

endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       armed_q,
  output logic       feed_ok
);

  logic first_hit;
  logic second_hit;

  assign first_hit  = is_write(wr_en, wr_addr, wr_data, ADR_KEY1, KEY_FIRST);
  assign second_hit = is_write(wr_en, wr_addr, wr_data, ADR_KEY2, KEY_SECOND);

  // the second byte only counts when the write right before it was the first byte
  assign feed_ok = armed_q && second_hit && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (clr) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      armed_q <= first_hit;
    end
  end

endmodule

// File: rtl/wdk_timer.sv
module wdk_timer #(
  parameter int BASE_LOG2 = 14,
  parameter int PRE_W     = 3,
  localparam int CNT_W    = BASE_LOG2 + (1 << PRE_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  // last count value before timeout: 2^(BASE_LOG2+pre) - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [PRE_W-1:0] p);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return (one << (BASE_LOG2 + int'(p))) - one;
  endfunction

  logic [CNT_W-1:0] last_val;

  assign last_val = last_count(pre);
  assign expire   = run && !clr && !reload && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || reload || expire) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdk_rst_pulse.sv
module wdk_rst_pulse #(
  parameter int RST_LEN = 24,
  localparam int LEN_W  = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_o
);

  localparam logic [LEN_W-1:0] LEN_V = LEN_W'(RST_LEN);

  logic [LEN_W-1:0] left_q;

  assign rst_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LEN_V;
    end else if (trigger) begin
      left_q <= LEN_V;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdk_causes.sv
module wdk_causes
  import wdk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] hw_set,
  input  logic               sw_wr,
  input  logic [N_FLAGS-1:0] sw_val,
  output logic [N_FLAGS-1:0] flags_q
);

  for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[gi] <= 1'b0;
      end else begin
        flags_q[gi] <= hw_set[gi] | (sw_wr ? sw_val[gi] : flags_q[gi]);
      end
    end
  end

endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int RST_LEN   = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       por_pulse,
  input  logic       lv_low,
  input  logic       osc_bad,
  output logic [7:0] ctrl_q,
  output logic [7:0] status_q,
  output logic       chip_rst_o
);

  localparam int PRE_W = 3;
  localparam int CNT_W = BASE_LOG2 + (1 << PRE_W) - 1;

  wdk_ctrl_t ctrl_act_q;
  wdk_ctrl_t ctrl_pend_q;

  logic               warm;
  logic               feed_ok;
  logic               key_armed;
  logic               tmr_expire;
  logic [CNT_W-1:0]   tmr_cnt;
  logic               ctrl_wr;
  logic               stat_wr;
  logic               sw_rst;
  logic               lv_trip;
  logic               osc_trip;
  logic               rst_trigger;
  logic [N_FLAGS-1:0] hw_set;
  logic [N_FLAGS-1:0] flags;

  assign warm     = chip_rst_o;
  assign ctrl_wr  = wr_en && (wr_addr == ADR_CTRL) && !warm;
  assign stat_wr  = wr_en && (wr_addr == ADR_STAT);
  assign sw_rst   = stat_wr && wr_data[7];
  assign lv_trip  = lv_low && ctrl_act_q.lv_en;
  assign osc_trip = osc_bad && ctrl_act_q.osc_en;

  assign rst_trigger = tmr_expire | por_pulse | lv_trip | osc_trip | sw_rst;

  always_comb begin
    hw_set          = '0;
    hw_set[FLG_POF] = por_pulse;
    hw_set[FLG_LVF] = lv_low;
    hw_set[FLG_OSF] = osc_bad;
    hw_set[FLG_TOF] = tmr_expire;
  end

  wdk_key_seq u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (warm),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .armed_q (key_armed),
    .feed_ok (feed_ok)
  );

  wdk_timer #(.BASE_LOG2(BASE_LOG2), .PRE_W(PRE_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (warm),
    .run    (ctrl_act_q.run),
    .pre    (ctrl_act_q.pre),
    .reload (feed_ok),
    .cnt_q  (tmr_cnt),
    .expire (tmr_expire)
  );

  wdk_rst_pulse #(.RST_LEN(RST_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (rst_trigger),
    .rst_o   (chip_rst_o)
  );

  wdk_causes u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (hw_set),
    .sw_wr   (stat_wr),
    .sw_val  (wr_data[N_FLAGS-1:0]),
    .flags_q (flags)
  );

  // control: writes land in the pending copy, a valid key commits it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_act_q  <= CTRL_DEFAULT;
      ctrl_pend_q <= CTRL_DEFAULT;
    end else if (warm) begin
      ctrl_act_q  <= CTRL_DEFAULT;
      ctrl_pend_q <= CTRL_DEFAULT;
    end else begin
      if (ctrl_wr) begin
        ctrl_pend_q <= ctrl_from_byte(wr_data);
      end
      if (feed_ok) begin
        ctrl_act_q <= ctrl_pend_q;
      end
    end
  end

  assign ctrl_q   = ctrl_act_q;
  assign status_q = {{(8-N_FLAGS){1'b0}}, flags};

endmodule

// File: rtl/wdk_chk.sv
module wdk_chk
  import wdk_pkg::*;
#(
  parameter int RST_LEN = 24,
  parameter int CNT_W   = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             lv_low,
  input logic [7:0]       ctrl_q,
  input logic [7:0]       status_q,
  input logic             chip_rst_o,
  input logic             feed_ok,
  input logic             tmr_expire,
  input logic [CNT_W-1:0] tmr_cnt
);

  localparam int HL_W = $clog2(RST_LEN + 2) + 1;

  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (chip_rst_o) begin
      if (hi_len != {HL_W{1'b1}}) hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  // R1
  rst_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst_o) |-> (hi_len == HL_W'(RST_LEN)));

  // R2
  timeout_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> (chip_rst_o && status_q[3]));

  // R3
  feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (tmr_cnt == '0));

  // R4
  feed_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> (wr_en && wr_addr == ADR_KEY2 && wr_data == KEY_SECOND));

  // R5
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(feed_ok) || $past(chip_rst_o)));

  // R6
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !feed_ok && !chip_rst_o) |=> $stable(tmr_cnt));

  // R8
  lv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv_low |=> status_q[1]);

  // R10
  pof_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !(wr_en && wr_addr == ADR_STAT)) |=> status_q[0]);

endmodule

bind wdk_top wdk_chk #(.RST_LEN(RST_LEN), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .lv_low     (lv_low),
  .ctrl_q     (ctrl_q),
  .status_q   (status_q),
  .chip_rst_o (chip_rst_o),
  .feed_ok    (feed_ok),
  .tmr_expire (tmr_expire),
  .tmr_cnt    (tmr_cnt)
);

// File: tb/sim_wdk_top.sv
`timescale 1ns/1ps
module sim_wdk_top;

  localparam int TMO      = 16384;
  localparam int PULSE    = 24;
  localparam int WD_LIMIT = 180000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       por_pulse;
  logic       lv_low;
  logic       osc_bad;
  logic [7:0] ctrl_q;
  logic [7:0] status_q;
  logic       chip_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  wdk_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .por_pulse(por_pulse), .lv_low(lv_low), .osc_bad(osc_bad),
    .ctrl_q(ctrl_q), .status_q(status_q), .chip_rst_o(chip_rst_o)
  );

  // {addr, data, expected ctrl after the write}; starts from ctrl 0x14
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'hF4, 8'h14},
    {2'd1, 8'hA5, 8'h14},
    {2'd2, 8'h5A, 8'hF4},
    {2'd0, 8'h37, 8'hF4},
    {2'd1, 8'hA5, 8'hF4},
    {2'd2, 8'h5B, 8'hF4},
    {2'd2, 8'h5A, 8'hF4},
    {2'd1, 8'hA5, 8'hF4},
    {2'd3, 8'h00, 8'hF4},
    {2'd2, 8'h5A, 8'hF4},
    {2'd1, 8'hA5, 8'hF4},
    {2'd1, 8'hA5, 8'hF4},
    {2'd2, 8'h5A, 8'h34},
    {2'd0, 8'h14, 8'h34},
    {2'd1, 8'hA5, 8'h34},
    {2'd2, 8'h5A, 8'h14}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
  endtask

  task automatic feed();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low();
    while (chip_rst_o) @(negedge clk);
  endtask

  task automatic high_len(output int n);
    n = 0;
    while (chip_rst_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic until_high(input int lim, output int n);
    n = 0;
    while (!chip_rst_o && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_sim();
    end
  end

  initial begin
    int n;
    logic [7:0] exp_ctrl;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
    por_pulse = 1'b0; lv_low = 1'b0; osc_bad = 1'b0;
    idle(3);
    rst_n = 1'b1;

    // R1: reset pulse length and reset values
    chk("R1 rst out high at release", chip_rst_o, 1);
    high_len(n);
    chk("R1 pulse length", n, PULSE);
    chk("R1 ctrl reset value", ctrl_q, 8'h14);
    chk("R1 status reset value", status_q, 8'h00);

    // R5 / R4: key sequences and pending control
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      exp_ctrl = VEC[i][7:0];
      chk($sformatf("R5 R4 vector %0d ctrl", i), ctrl_q, exp_ctrl);
    end

    // R11: software reset restores control
    wr(2'd0, 8'hF4); feed();
    chk("R11 ctrl before sw reset", ctrl_q, 8'hF4);
    wr(2'd3, 8'h80);
    chk("R11 sw reset asserts", chip_rst_o, 1);
    high_len(n);
    chk("R11 sw pulse length", n, PULSE);
    chk("R11 ctrl default after", ctrl_q, 8'h14);

    // R2: default timeout
    until_high(TMO + 100, n);
    chk("R2 default timeout cycles", n, TMO);
    chk("R2 timeout flag", status_q, 8'h08);
    high_len(n);
    chk("R2 timeout pulse length", n, PULSE);

    // R10: software load of flags
    wr(2'd3, 8'h00);
    chk("R10 sw clear flags", status_q, 8'h00);
    wr(2'd3, 8'h01);
    chk("R10 sw set pof", status_q, 8'h01);
    wr(2'd3, 8'h00);

    // R3: feed restarts the count
    idle(10000);
    feed();
    until_high(TMO + 100, n);
    chk("R3 timeout measured from feed", n, TMO);
    wait_low();

    // R4: aborted key does not restart
    idle(8000);
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h00);
    until_high(TMO + 100, n);
    chk("R4 aborted key no reload", n, TMO - 8002);
    wait_low();

    // R6: stopping the count
    wr(2'd0, 8'h10); feed();
    chk("R6 run cleared", ctrl_q, 8'h10);
    until_high(20000, n);
    chk("R6 no timeout while stopped", chip_rst_o, 0);
    wr(2'd3, 8'h80);
    wait_low();

    // R7: prescale 1 doubles the timeout
    wr(2'd0, 8'h34); feed();
    until_high(2 * TMO + 100, n);
    chk("R7 prescale 1 timeout", n, 2 * TMO);
    wait_low();
    chk("R7 ctrl back to default", ctrl_q, 8'h14);

    // R8: low voltage
    wr(2'd3, 8'h00);
    lv_low = 1'b1; @(negedge clk); lv_low = 1'b0;
    chk("R8 lv reset when enabled", chip_rst_o, 1);
    chk("R8 lv flag", status_q, 8'h02);
    wait_low();
    wr(2'd0, 8'h04);
    chk("R8 lv_en still set before key", ctrl_q, 8'h14);
    feed();
    chk("R8 lv_en cleared", ctrl_q, 8'h04);
    wr(2'd3, 8'h00);
    lv_low = 1'b1; @(negedge clk); lv_low = 1'b0;
    chk("R8 no lv reset when disabled", chip_rst_o, 0);
    chk("R8 lv flag when disabled", status_q, 8'h02);
    idle(3);
    chk("R8 still no reset", chip_rst_o, 0);

    // R9: oscillator fail
    wr(2'd3, 8'h00);
    osc_bad = 1'b1; @(negedge clk); osc_bad = 1'b0;
    chk("R9 no osc reset by default", chip_rst_o, 0);
    chk("R9 osc flag", status_q, 8'h04);
    wr(2'd0, 8'h0C); feed();
    chk("R9 osc_en set", ctrl_q, 8'h0C);
    wr(2'd3, 8'h00);
    osc_bad = 1'b1; @(negedge clk); osc_bad = 1'b0;
    chk("R9 osc reset when enabled", chip_rst_o, 1);
    chk("R9 osc flag set again", status_q, 8'h04);
    wait_low();
    chk("R9 ctrl default after", ctrl_q, 8'h14);

    // R10: power-on flag, stickiness, hardware priority
    wr(2'd3, 8'h00);
    por_pulse = 1'b1; @(negedge clk); por_pulse = 1'b0;
    chk("R10 por reset", chip_rst_o, 1);
    chk("R10 pof set", status_q, 8'h01);
    wait_low();
    chk("R10 pof survives warm reset", status_q, 8'h01);
    lv_low = 1'b1; wr(2'd3, 8'h00); lv_low = 1'b0;
    chk("R10 hw set beats sw clear", status_q, 8'h02);

    done = 1'b1;
    finish_sim();
  end

endmodule